// File: doc/BRIEF.md
# Pointer-Steered Data Memory Front End

This block sits between the operand path of a small 8-bit core and its data memory. The core presents one direct 8-bit address together with a read strobe, a write strobe and write data. The block decides which storage that address reaches and returns read data in the same cycle.

Two addresses are windows with no storage of their own. Any access to a window is redirected to the location held in a 7-bit pointer register that belongs to that window. Both pointers sit in the same address space, so software can load them directly or through a window. The accumulator also has a fixed data address and is driven out continuously for the ALU. Every other location in the lower half of the space is plain RAM.

One operation carries a single address, so a copy from one window straight to the other cannot be expressed. Such a copy goes through the accumulator in two operations.

Top module: `ptr_dmem_front`

## Requirements
- R1: After synchronous reset, both pointers and the accumulator are zero. A read of 01h or 03h then returns 80h and `acc_out` is 00h.
- R2: A write to 01h (pointer 0) or 03h (pointer 1) keeps only bits 6:0 of the data. A later read of that address returns the stored value with bit 7 set to 1.
- R3: A read or write at 00h reaches the location whose 7-bit address is held in pointer 0.
- R4: A read or write at 02h reaches the location whose 7-bit address is held in pointer 1.
- R5: Locations 00h and 02h hold no data. When a window's pointer holds 00h or 02h, a read through the window returns 00h and a write through it changes nothing.
- R6: The accumulator is at 05h, both directly and through a window. Its value appears on `acc_out` in the cycle after the write.
- R7: Addresses 04h and 06h–7Fh are RAM. A written value reads back, direct or through a window, from the cycle after the write.
- R8: Addresses 80h–FFh are unmapped. A read returns 00h and a write changes no pointer, accumulator or RAM location.
- R9: While `rd_en` is low, `rd_data` is 00h.
- R10: A read is combinational and a write takes effect at the rising edge. When both strobes are high in one cycle, `rd_data` shows the contents from before that write.
- R11: When a window's pointer holds 01h or 03h, an access through the window reads or writes that pointer, with the same 7-bit store and bit-7 readback as R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Direct data address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational |
| acc_out | output | 8 | Current accumulator value |

## Verification
A read and a write can fall in the same cycle at the same address. This matters most when the write changes the pointer that steers the read, or when a window is aimed at its own pointer, which the bench sets up. The bench raises both strobes together on 01h, and on 00h with pointer 0 aimed at 01h. It judges `rd_data` before the edge against the old contents. After the edge it reads back the new pointer value and the location that pointer now selects.

// File: rtl/ptrmem_pkg.sv
package ptrmem_pkg;
  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_PTR0,
    TGT_PTR1,
    TGT_ACC,
    TGT_RAM
  } tgt_e;

  localparam int unsigned NUM_PTR  = 2;
  localparam int unsigned WIN0_LOC = 0;
  localparam int unsigned PTR0_LOC = 1;
  localparam int unsigned WIN1_LOC = 2;
  localparam int unsigned PTR1_LOC = 3;
  localparam int unsigned ACC_LOC  = 5;
endpackage

// File: rtl/ptrmem_resolver.sv
module ptrmem_resolver
  import ptrmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PTR_W  = 7
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PTR_W-1:0]  ptr0,
  input  logic [PTR_W-1:0]  ptr1,
  output logic [PTR_W-1:0]  loc,
  output tgt_e              tgt
);
  localparam logic [PTR_W-1:0] W0 = PTR_W'(WIN0_LOC);
  localparam logic [PTR_W-1:0] W1 = PTR_W'(WIN1_LOC);
  localparam logic [PTR_W-1:0] P0 = PTR_W'(PTR0_LOC);
  localparam logic [PTR_W-1:0] P1 = PTR_W'(PTR1_LOC);
  localparam logic [PTR_W-1:0] AC = PTR_W'(ACC_LOC);

  logic             in_space;
  logic [PTR_W-1:0] direct_loc;

  assign in_space   = ~|addr[ADDR_W-1:PTR_W];
  assign direct_loc = addr[PTR_W-1:0];

  // first stage: a window address is replaced by its pointer
  always_comb begin
    if (direct_loc == W0)      loc = ptr0;
    else if (direct_loc == W1) loc = ptr1;
    else                       loc = direct_loc;
  end

  // second stage: classify the effective location; a window reached
  // through a pointer has no backing and resolves to nothing
  always_comb begin
    if (!in_space) begin
      tgt = TGT_NONE;
    end else begin
      case (loc)
        W0, W1:  tgt = TGT_NONE;
        P0:      tgt = TGT_PTR0;
        P1:      tgt = TGT_PTR1;
        AC:      tgt = TGT_ACC;
        default: tgt = TGT_RAM;
      endcase
    end
  end
endmodule

// File: rtl/ptrmem_ptr_regs.sv
module ptrmem_ptr_regs #(
  parameter int unsigned PTR_W = 7,
  parameter int unsigned NUM   = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM-1:0]            we,
  input  logic [PTR_W-1:0]          wdata,
  output logic [NUM-1:0][PTR_W-1:0] ptr_q
);
  for (genvar i = 0; i < NUM; i++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst)        ptr_q[i] <= '0;
      else if (we[i]) ptr_q[i] <= wdata;
    end
  end
endmodule

// File: rtl/ptrmem_store.sv
module ptrmem_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PTR_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ram_we,
  input  logic              acc_we,
  input  logic [PTR_W-1:0]  loc,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] acc_q
);
  localparam int unsigned DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // no reset on the array so it can map onto memory resources
  always_ff @(posedge clk) begin
    if (ram_we) mem[loc] <= wdata;
  end

  assign ram_rdata = mem[loc];

  always_ff @(posedge clk) begin
    if (rst)         acc_q <= '0;
    else if (acc_we) acc_q <= wdata;
  end
endmodule

// File: rtl/ptr_dmem_front.sv
module ptr_dmem_front
  import ptrmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PTR_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] acc_out
);
  localparam int unsigned PAD_W = DATA_W - PTR_W;

  logic [NUM_PTR-1:0][PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0]  ptr0_q;
  logic [PTR_W-1:0]  ptr1_q;
  logic [PTR_W-1:0]  loc;
  tgt_e              tgt;
  logic [NUM_PTR-1:0] ptr_we;
  logic              ram_we;
  logic              acc_we;
  logic [DATA_W-1:0] ram_rdata;
  logic [DATA_W-1:0] acc_q;

  assign ptr0_q = ptr_q[0];
  assign ptr1_q = ptr_q[1];

  ptrmem_resolver #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_res (
    .addr (addr),
    .ptr0 (ptr0_q),
    .ptr1 (ptr1_q),
    .loc  (loc),
    .tgt  (tgt)
  );

  assign ptr_we[0] = wr_en && (tgt == TGT_PTR0);
  assign ptr_we[1] = wr_en && (tgt == TGT_PTR1);
  assign ram_we    = wr_en && (tgt == TGT_RAM);
  assign acc_we    = wr_en && (tgt == TGT_ACC);

  ptrmem_ptr_regs #(.PTR_W(PTR_W), .NUM(NUM_PTR)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .we    (ptr_we),
    .wdata (wr_data[PTR_W-1:0]),
    .ptr_q (ptr_q)
  );

  ptrmem_store #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .ram_we    (ram_we),
    .acc_we    (acc_we),
    .loc       (loc),
    .wdata     (wr_data),
    .ram_rdata (ram_rdata),
    .acc_q     (acc_q)
  );

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (tgt)
        TGT_PTR0: rd_data = {{PAD_W{1'b1}}, ptr0_q};
        TGT_PTR1: rd_data = {{PAD_W{1'b1}}, ptr1_q};
        TGT_ACC:  rd_data = acc_q;
        TGT_RAM:  rd_data = ram_rdata;
        default:  rd_data = '0;
      endcase
    end
  end

  assign acc_out = acc_q;
endmodule

// File: rtl/ptr_dmem_front_chk.sv
module ptr_dmem_front_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PTR_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] acc_out,
  input logic [PTR_W-1:0]  ptr0_q,
  input logic [PTR_W-1:0]  ptr1_q
);
  logic hi_zero;
  logic self0;
  logic self1;
  assign hi_zero = ~|addr[ADDR_W-1:PTR_W];
  assign self0 = (ptr0_q == PTR_W'(0)) || (ptr0_q == PTR_W'(2));
  assign self1 = (ptr1_q == PTR_W'(0)) || (ptr1_q == PTR_W'(2));

  AST_RESET_PTRS: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ptr0_q == '0 && ptr1_q == '0 && acc_out == '0)); // R1

  AST_PTR0_STORE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hi_zero && addr[PTR_W-1:0] == PTR_W'(1)) |=> ptr0_q == $past(wr_data[PTR_W-1:0])); // R2

  AST_PTR_READ_TOP: assert property (@(posedge clk) disable iff (rst)
    (rd_en && hi_zero && (addr[PTR_W-1:0] == PTR_W'(1) || addr[PTR_W-1:0] == PTR_W'(3))) |-> rd_data[DATA_W-1]); // R2

  AST_WIN0_SELF_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(0) && self0) |-> rd_data == '0); // R5

  AST_WIN1_SELF_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(2) && self1) |=> ($stable(ptr0_q) && $stable(ptr1_q) && $stable(acc_out))); // R5

  AST_ACC_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(5)) |=> acc_out == $past(wr_data)); // R6

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !hi_zero) |-> rd_data == '0); // R8

  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !hi_zero) |=> ($stable(ptr0_q) && $stable(ptr1_q) && $stable(acc_out))); // R8

  AST_IDLE_READ: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> rd_data == '0); // R9
endmodule

bind ptr_dmem_front ptr_dmem_front_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .addr    (addr),
  .rd_en   (rd_en),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .acc_out (acc_out),
  .ptr0_q  (ptr0_q),
  .ptr1_q  (ptr1_q)
);

// File: tb/ptr_dmem_front_bench.sv
module ptr_dmem_front_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr = '0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [7:0] acc_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] m_ram [128];
  logic [6:0] m_p0;
  logic [6:0] m_p1;
  logic [7:0] m_acc;

  always #5 clk = ~clk;

  ptr_dmem_front u_ptr_dmem_front (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .acc_out(acc_out)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] eff_loc(input logic [7:0] a);
    if (a[6:0] == 7'd0) return {1'b0, m_p0};
    if (a[6:0] == 7'd2) return {1'b0, m_p1};
    return {1'b0, a[6:0]};
  endfunction

  function automatic logic [7:0] m_read(input logic [7:0] a);
    logic [7:0] l;
    if (a[7]) return 8'h00;
    l = eff_loc(a);
    case (l)
      8'd0, 8'd2: return 8'h00;
      8'd1: return {1'b1, m_p0};
      8'd3: return {1'b1, m_p1};
      8'd5: return m_acc;
      default: return m_ram[l[6:0]];
    endcase
  endfunction

  task automatic m_write(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] l;
    if (!a[7]) begin
      l = eff_loc(a);
      case (l)
        8'd0, 8'd2: ;
        8'd1: m_p0 = d[6:0];
        8'd3: m_p1 = d[6:0];
        8'd5: m_acc = d;
        default: m_ram[l[6:0]] = d;
      endcase
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    m_write(a, d);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1; wr_en = 1'b0;
    #1;
    check(rd_data, m_read(a), tag);
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%02h expected=%02h", 8'h00, 8'h01);
    finish_run();
  end

  initial begin
    m_p0 = '0; m_p1 = '0; m_acc = '0;
    for (int i = 0; i < 128; i++) m_ram[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd(8'h01, "R1 ptr0 after reset");
    rd(8'h03, "R1 ptr1 after reset");
    #1 check(acc_out, 8'h00, "R1 acc after reset");

    // R9 idle read on a mapped pointer address
    @(negedge clk); addr = 8'h01; rd_en = 1'b0; #1;
    check(rd_data, 8'h00, "R9 rd_en low");

    // R7 fill all RAM locations directly (pointers stay at 00h so windows drop)
    for (int a = 4; a < 128; a++)
      if (a != 5) wr(8'(a), 8'((a * 37 + 11) & 8'hff));
    for (int a = 4; a < 128; a++)
      if (a != 5) rd(8'(a), "R7 direct RAM readback");

    // R2 pointer store keeps 7 bits, bit 7 reads back set
    wr(8'h01, 8'hff); rd(8'h01, "R2 ptr0 ff");
    wr(8'h03, 8'h2a); rd(8'h03, "R2 ptr1 2a");

    // R6 accumulator direct
    wr(8'h05, 8'hc3);
    #1 check(acc_out, 8'hc3, "R6 acc_out after direct write");
    rd(8'h05, "R6 acc direct read");

    // R3 / R5 / R6 / R11 sweep window 0 over every 7-bit pointer value
    for (int p = 0; p < 128; p++) begin
      wr(8'h01, 8'(p));
      rd(8'h00, "R3 R5 R11 read via window0");
    end

    // R4 / R5 / R11 write through window 1 to every location, read direct
    for (int p = 0; p < 128; p++) begin
      wr(8'h03, 8'(p));
      wr(8'h02, 8'((p * 91 + 5) & 8'hff));
      rd(8'(p), "R4 R5 R11 direct read after window1 write");
      rd(8'h03, "R11 ptr1 after window1 write");
    end
    wr(8'h05, 8'h00);
    wr(8'h03, 8'h05); wr(8'h02, 8'h7e);
    #1 check(acc_out, 8'h7e, "R6 acc via window1");

    // R5 self-referencing write on window 0 leaves state unchanged
    wr(8'h01, 8'h02); wr(8'h00, 8'h99);
    rd(8'h01, "R5 ptr0 kept"); rd(8'h03, "R5 ptr1 kept");
    #1 check(acc_out, 8'h7e, "R5 acc kept");

    // R8 unmapped range: sweep reads and a few writes
    for (int a = 128; a < 256; a++) rd(8'(a), "R8 unmapped read");
    wr(8'h80, 8'h11); wr(8'h81, 8'h22); wr(8'h85, 8'h33); wr(8'h90, 8'h44);
    rd(8'h01, "R8 ptr0 unchanged"); rd(8'h03, "R8 ptr1 unchanged");
    rd(8'h05, "R8 acc unchanged"); rd(8'h10, "R8 ram 10h unchanged");
    rd(8'h04, "R8 ram 04h unchanged");

    // R10 simultaneous read and write on ptr0: read shows old value
    wr(8'h01, 8'h10);
    @(negedge clk);
    addr = 8'h01; wr_data = 8'h20; wr_en = 1'b1; rd_en = 1'b1; #1;
    check(rd_data, 8'h90, "R10 same-cycle read old ptr0");
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0; m_write(8'h01, 8'h20);
    rd(8'h01, "R10 ptr0 updated after edge");
    rd(8'h00, "R10 window0 follows new ptr0");

    // R10 R11 window0 aimed at its own pointer, read and write together
    wr(8'h01, 8'h01);
    @(negedge clk);
    addr = 8'h00; wr_data = 8'h47; wr_en = 1'b1; rd_en = 1'b1; #1;
    check(rd_data, 8'h81, "R10 R11 self pointer read old");
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0; m_write(8'h00, 8'h47);
    rd(8'h01, "R11 ptr0 written through window");
    rd(8'h00, "R11 window0 at new target");

    // R10 RAM same-cycle read/write
    @(negedge clk);
    addr = 8'h40; wr_data = 8'h5a; wr_en = 1'b1; rd_en = 1'b1; #1;
    check(rd_data, m_read(8'h40), "R10 ram same-cycle old value");
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0; m_write(8'h40, 8'h5a);
    rd(8'h40, "R10 ram new value");

    finish_run();
  end
endmodule